// File: doc/BRIEF.md
# Overlay Window Sequencer

This block sits in every router of a reply network and decides which overlay circuit the router's crossbar serves at each moment. Time is split into epochs, and each epoch is split into a repeating series of windows, one per overlay (one overlay per memory controller). A short local counter times the current window. A wider global counter adds up whole window lengths until the epoch length is reached. At that point a freshly broadcast set of window lengths is taken in and the sequence starts again at overlay 0.

On every window change the block reads a design-time constant table. The table has one row per overlay, and each row lists the input source for every output port of the crossbar. The block presents the row together with the overlay number and a one-cycle update pulse to the turn selection logic. Table contents depend on the router's location, which is given as a parameter.

Top module: `overlay_window_seq`

## Requirements
- R1: While `rst_n` is low on a clock edge, the block resets. After reset, `ovl_idx` is 0, `cfg_upd` is 0, `xbar_cfg` holds row 0 of the table, and all N window lengths equal `dflt_len`. Both counters and the internal overlay index are zero.
- R2: The first window after reset or after an epoch reload ends on the (T0+1)-th clock edge. Every later window i ends T_i edges after the previous window ended. A window whose length is zero ends on the next edge.
- R3: Each window end moves the internal overlay index to (i+1) mod N, so the overlays are presented in the order 0, 1, ..., N-1, 0, and so on.
- R4: Each window end adds the elapsed local count to the global count. On the first edge at which the global count is at least `epoch_len`, the block does three things: it loads window i from `bcast_lens[10*i+9:10*i]`, it clears both counters, and it returns the overlay index to 0. No window is counted on that edge.
- R5: `bcast_lens` is captured only on the epoch reload edge. Changing it at any other time has no effect on window timing.
- R6: A window end or epoch reload on edge k gives `cfg_upd` = 1 for the single cycle after edge k+1. In that cycle `ovl_idx` is the newly selected overlay and `xbar_cfg` is that overlay's table row.
- R7: Output port p of overlay o uses `xbar_cfg[4*p+3:4*p]`, and its value is (3*o + 7*p + ROUTER_ID) mod 11. Codes 0 to 4 select the bypass link of input port n. Codes 5 to 9 select the latch of input port n-5. Code 10 means no mapping.
- R8: `xbar_cfg` and `ovl_idx` do not change in any cycle where `cfg_upd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| epoch_len | input | EPOCH_W | Epoch length in cycles |
| dflt_len | input | LEN_W | Window length used for every overlay after reset |
| bcast_lens | input | N_OVL*LEN_W | Broadcast window lengths, field i for overlay i |
| xbar_cfg | output | PORTS*SRC_W | Active crossbar configuration row |
| cfg_upd | output | 1 | One-cycle pulse when a new configuration is presented |
| ovl_idx | output | IDX_W | Overlay number of the presented configuration |

## Verification
Four properties are checked on every cycle:
- the configuration and overlay number hold between pulses;
- each presented overlay follows its predecessor modulo N or returns to 0;
- every internal index move is followed by a pulse;
- the local count never exceeds the current window length, and the counters clear after the epoch limit is reached.

Only the bench scenarios can show the exact edges on which windows end. They also show that the first window of an epoch is one cycle longer, that broadcast lengths take effect only from the next epoch, that a mid-epoch change to the broadcast word leaves the timing untouched, and that a second reset restores the default lengths.

// File: rtl/overlay_window_seq.sv
module overlay_window_seq #(
  parameter int N_OVL     = 4,
  parameter int LEN_W     = 10,
  parameter int EPOCH_W   = 14,
  parameter int PORTS     = 5,
  parameter int SRC_W     = 4,
  parameter int ROUTER_ID = 0,
  localparam int IDX_W    = (N_OVL > 1) ? $clog2(N_OVL) : 1,
  localparam int CFG_W    = PORTS * SRC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EPOCH_W-1:0]     epoch_len,
  input  logic [LEN_W-1:0]       dflt_len,
  input  logic [N_OVL*LEN_W-1:0] bcast_lens,
  output logic [CFG_W-1:0]       xbar_cfg,
  output logic                   cfg_upd,
  output logic [IDX_W-1:0]       ovl_idx
);

  localparam int NCODE = 2 * PORTS + 1;

  function automatic logic [CFG_W-1:0] rom_row(input logic [IDX_W-1:0] o);
    logic [CFG_W-1:0] row;
    row = '0;
    for (int p = 0; p < PORTS; p++)
      row[p*SRC_W +: SRC_W] = SRC_W'((int'(o) * 3 + p * 7 + ROUTER_ID) % NCODE);
    return row;
  endfunction

  logic [LEN_W-1:0]   wlen [N_OVL];
  logic [LEN_W-1:0]   loc;
  logic [EPOCH_W:0]   glob;
  logic [IDX_W-1:0]   idx;
  logic               moved;

  logic [LEN_W-1:0]   cur_len;
  logic               epoch_end;
  logic               win_end;
  logic [IDX_W-1:0]   next_idx;

  assign cur_len   = wlen[idx];
  assign epoch_end = glob >= {1'b0, epoch_len};
  assign win_end   = !epoch_end && (loc >= cur_len);
  assign next_idx  = (idx == IDX_W'(N_OVL - 1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_OVL; i++) wlen[i] <= dflt_len;
      loc      <= '0;
      glob     <= '0;
      idx      <= '0;
      moved    <= 1'b0;
      cfg_upd  <= 1'b0;
      ovl_idx  <= '0;
      xbar_cfg <= rom_row('0);
    end else begin
      moved   <= epoch_end || win_end;
      cfg_upd <= moved;
      if (moved) begin
        xbar_cfg <= rom_row(idx);
        ovl_idx  <= idx;
      end
      if (epoch_end) begin
        for (int i = 0; i < N_OVL; i++) wlen[i] <= bcast_lens[i*LEN_W +: LEN_W];
        loc  <= '0;
        glob <= '0;
        idx  <= '0;
      end else if (win_end) begin
        idx  <= next_idx;
        glob <= glob + {{(EPOCH_W+1-LEN_W){1'b0}}, loc};
        loc  <= LEN_W'(1);
      end else begin
        loc <= loc + 1'b1;
      end
    end
  end

endmodule

module overlay_window_seq_chk #(
  parameter int N_OVL   = 4,
  parameter int LEN_W   = 10,
  parameter int EPOCH_W = 14,
  parameter int IDX_W   = 2,
  parameter int CFG_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [EPOCH_W-1:0] epoch_len,
  input logic [CFG_W-1:0]   xbar_cfg,
  input logic               cfg_upd,
  input logic [IDX_W-1:0]   ovl_idx,
  input logic [IDX_W-1:0]   idx,
  input logic [LEN_W-1:0]   loc,
  input logic [LEN_W-1:0]   cur_len,
  input logic [EPOCH_W:0]   glob
);

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_upd |-> ($stable(xbar_cfg) && $stable(ovl_idx)));

  assert_idx_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd |-> (ovl_idx == '0 ||
                 ovl_idx == (($past(ovl_idx) == IDX_W'(N_OVL - 1)) ? '0 : $past(ovl_idx) + 1'b1)));

  assert_upd_follows_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != $past(idx)) |=> cfg_upd);

  assert_local_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loc <= cur_len || loc == LEN_W'(1));

  assert_epoch_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (glob >= {1'b0, epoch_len}) |=> (glob == '0 && loc == '0 && idx == '0));

endmodule

bind overlay_window_seq overlay_window_seq_chk #(
  .N_OVL(N_OVL), .LEN_W(LEN_W), .EPOCH_W(EPOCH_W), .IDX_W(IDX_W), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .epoch_len(epoch_len), .xbar_cfg(xbar_cfg),
  .cfg_upd(cfg_upd), .ovl_idx(ovl_idx), .idx(idx), .loc(loc),
  .cur_len(cur_len), .glob(glob)
);

// File: tb/overlay_window_seq_tb.sv
`timescale 1ns/1ps
module overlay_window_seq_tb;
  localparam int N = 4, LW = 10, EW = 14, PORTS = 5, SW = 4, RID = 2;

  logic clk = 0, rst_n = 0;
  logic [EW-1:0] epoch_len = 14'd20;
  logic [LW-1:0] dflt_len = 10'd3;
  logic [N*LW-1:0] bcast_lens;
  logic [PORTS*SW-1:0] xbar_cfg;
  logic cfg_upd;
  logic [1:0] ovl_idx;
  int errs = 0, checks = 0;
  bit done = 0;

  localparam logic [N*LW-1:0] LENS_A = {10'd4, 10'd1, 10'd5, 10'd2};
  localparam logic [N*LW-1:0] LENS_X = {10'd7, 10'd7, 10'd7, 10'd7};

  localparam int NV = 20;
  localparam int UPD_E [NV] = '{5, 8, 11, 14, 17, 20, 23, 24, 27, 32,
                                33, 37, 39, 44, 45, 46, 49, 54, 55, 59};
  localparam int UPD_I [NV] = '{1, 2, 3, 0, 1, 2, 3, 0, 1, 2,
                                3, 0, 1, 2, 3, 0, 1, 2, 3, 0};

  always #2 clk = ~clk;

  overlay_window_seq #(.N_OVL(N), .LEN_W(LW), .EPOCH_W(EW), .PORTS(PORTS),
                       .SRC_W(SW), .ROUTER_ID(RID)) u_dut (
    .clk(clk), .rst_n(rst_n), .epoch_len(epoch_len), .dflt_len(dflt_len),
    .bcast_lens(bcast_lens), .xbar_cfg(xbar_cfg), .cfg_upd(cfg_upd), .ovl_idx(ovl_idx));

  function automatic logic [PORTS*SW-1:0] exp_row(input int o);
    logic [PORTS*SW-1:0] r;
    for (int p = 0; p < PORTS; p++) r[p*SW +: SW] = SW'((3*o + 7*p + RID) % 11);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bcast_lens = LENS_A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 upd after reset", 32'(cfg_upd), 0);
    chk("R1 idx after reset", 32'(ovl_idx), 0);
    chk("R1 cfg row0 / R7", 32'(xbar_cfg), 32'(exp_row(0)));
    rst_n = 1;
    for (int e = 1; e <= 60; e++) begin
      int hit;
      @(posedge clk);
      @(negedge clk);
      hit = -1;
      for (int k = 0; k < NV; k++) if (UPD_E[k] == e) hit = k;
      chk(e <= 23 ? "R2 default windows" : "R4 broadcast windows", 32'(cfg_upd), hit >= 0 ? 1 : 0);
      if (hit >= 0) begin
        chk("R3 overlay order / R6", 32'(ovl_idx), 32'(UPD_I[hit]));
        chk("R7 table row", 32'(xbar_cfg), 32'(exp_row(UPD_I[hit])));
      end
      if (e == 24) bcast_lens = LENS_X;
      if (e == 44) bcast_lens = LENS_A;
    end
    chk("R5 mid-epoch broadcast ignored", 32'(ovl_idx), 0);

    dflt_len = 10'd2;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset again idx", 32'(ovl_idx), 0);
    chk("R8 cfg back to row0", 32'(xbar_cfg), 32'(exp_row(0)));
    rst_n = 1;
    for (int e = 1; e <= 7; e++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1 defaults restored", 32'(cfg_upd), (e == 4 || e == 6) ? 1 : 0);
      if (e == 4) chk("R3 first advance", 32'(ovl_idx), 1);
      if (e == 6) chk("R3 second advance", 32'(ovl_idx), 2);
      if (e == 5) chk("R8 hold between pulses", 32'(xbar_cfg), 32'(exp_row(1)));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule